// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the command and address pins of a four-bank single-data-rate SDRAM from reset until the memory is ready for ordinary traffic. After reset it holds the bus idle with NOP commands for a programmable settling wait. It then runs a fixed bring-up order: a precharge that covers every bank, two auto-refresh commands, and a load of the mode register. Each command is followed by a timed gap. Once the last gap has elapsed, a ready flag goes high and the bus stays at NOP so that a memory controller can take over.

The mode word is assembled field by field from four configuration inputs: burst length, burst ordering, CAS latency and write-burst policy. These inputs are sampled in the cycle the load is issued. All pins come straight from flops clocked on the rising edge. Chip select is held low throughout, so the command is set by the RAS, CAS and WE levels alone.

Top module: `sdram_init_seq`

## Requirements
- R1: While `rst_n` is low the outputs read NOP ({cs_n,ras_n,cas_n,we_n} = 4'b0111), `sd_ba` and `sd_addr` are zero, and `init_done` is low.
- R2: After reset is released the bus shows NOP for exactly WAIT_CYCLES rising edges. The precharge is registered on edge WAIT_CYCLES+1.
- R3: The first command is a precharge ({cs_n,ras_n,cas_n,we_n} = 4'b0010) with `sd_addr[10]` high, which selects all banks.
- R4: Exactly two auto-refresh commands (4'b0001) follow. The first is T_RP edges after the precharge and the second is T_RFC edges after the first.
- R5: The mode-register load (4'b0000) comes T_RFC edges after the second refresh.
- R6: The load carries burst length in `sd_addr[2:0]`, burst ordering in bit 3, CAS latency in bits 6:4, zeros in bits 8:7, write-burst mode in bit 9, zeros in bits 12:10, and `sd_ba` = 0.
- R7: Every cycle that carries none of these four commands shows NOP. `init_done` rises T_MRD edges after the load.
- R8: Once `init_done` is high, it stays high and the bus stays at NOP, whatever the configuration inputs do.
- R9: Asserting reset at any point of the sequence restarts it from the wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_burst_len | input | 3 | Burst-length code for the mode word |
| cfg_burst_seq | input | 1 | Burst ordering (0 sequential, 1 interleaved) |
| cfg_cas_lat | input | 3 | CAS-latency code |
| cfg_wr_single | input | 1 | Write-burst mode bit |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 13 | Row / mode address |
| init_done | output | 1 | High once the memory is ready |

## Verification
The assertions assume that `rst_n` is synchronous and is held low for at least one edge. They also assume that every gap parameter is at least one and that the configuration inputs are stable around the edge where the load is issued. The bench drives every input at the falling edge and changes the configuration only while reset is held, or after `init_done`, except where it tests R8. The gap parameters are set to small distinct values so that a swapped gap shows up as a wrong command cycle.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;
    // {ras_n, cas_n, we_n} with chip select held low
    typedef enum logic [2:0] {
        CMD_MRS = 3'b000,
        CMD_REF = 3'b001,
        CMD_PRE = 3'b010,
        CMD_NOP = 3'b111
    } sd_cmd_t;

    typedef enum logic [2:0] {
        ST_WAIT,
        ST_TRP,
        ST_TRFC1,
        ST_TRFC2,
        ST_TMRD,
        ST_READY
    } init_state_t;

    localparam int ALL_BANK_BIT = 10;
endpackage

// File: rtl/sdram_mode_word.sv
module sdram_mode_word #(
    parameter int ADDR_W = 13
) (
    input  logic [2:0]        burst_len,
    input  logic              burst_seq,
    input  logic [2:0]        cas_lat,
    input  logic              wr_single,
    output logic [ADDR_W-1:0] word
);
    always_comb begin
        word      = '0;
        word[2:0] = burst_len;
        word[3]   = burst_seq;
        word[6:4] = cas_lat;
        word[8:7] = 2'b00;
        word[9]   = wr_single;
    end
endmodule

// File: rtl/sdram_gap_timer.sv
module sdram_gap_timer #(
    parameter int CNT_W   = 8,
    parameter int RST_VAL = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load)              cnt_d = load_val;
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
        else                   cnt_d = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= CNT_W'(RST_VAL);
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    AST_TIMER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val)));                       // R7
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int CLK_MHZ     = 50,
    parameter int WAIT_US     = 100,
    parameter int WAIT_CYCLES = CLK_MHZ * WAIT_US,
    parameter int T_RP        = 3,
    parameter int T_RFC       = 7,
    parameter int T_MRD       = 2,
    parameter int ADDR_W      = 13,
    parameter int BANK_W      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_burst_len,
    input  logic              cfg_burst_seq,
    input  logic [2:0]        cfg_cas_lat,
    input  logic              cfg_wr_single,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ADDR_W-1:0] sd_addr,
    output logic              init_done
);
    localparam int MAX_GAP = (T_RFC > T_RP) ? ((T_RFC > T_MRD) ? T_RFC : T_MRD)
                                            : ((T_RP > T_MRD) ? T_RP : T_MRD);
    localparam int MAX_CNT = (WAIT_CYCLES > MAX_GAP) ? WAIT_CYCLES : MAX_GAP;
    localparam int CNT_W   = $clog2(MAX_CNT + 1);

    typedef struct packed {
        init_state_t       state;
        sd_cmd_t           cmd;
        logic [BANK_W-1:0] ba;
        logic [ADDR_W-1:0] addr;
        logic              done;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic             gap_expired;
    logic             gap_load;
    logic [CNT_W-1:0] gap_val;
    logic [ADDR_W-1:0] mode_word;
    logic [ADDR_W-1:0] pre_word;

    always_comb begin
        pre_word               = '0;
        pre_word[ALL_BANK_BIT] = 1'b1;
    end

    sdram_mode_word #(.ADDR_W(ADDR_W)) u_mode (
        .burst_len (cfg_burst_len),
        .burst_seq (cfg_burst_seq),
        .cas_lat   (cfg_cas_lat),
        .wr_single (cfg_wr_single),
        .word      (mode_word)
    );

    sdram_gap_timer #(.CNT_W(CNT_W), .RST_VAL(WAIT_CYCLES)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .load_val (gap_val),
        .expired  (gap_expired)
    );

    always_comb begin
        r_d      = r_q;
        r_d.cmd  = CMD_NOP;
        r_d.ba   = '0;
        r_d.addr = '0;
        gap_load = 1'b0;
        gap_val  = '0;
        if (gap_expired) begin
            unique case (r_q.state)
                ST_WAIT: begin
                    r_d.state = ST_TRP;
                    r_d.cmd   = CMD_PRE;
                    r_d.addr  = pre_word;
                    gap_load  = 1'b1;
                    gap_val   = CNT_W'(T_RP - 1);
                end
                ST_TRP: begin
                    r_d.state = ST_TRFC1;
                    r_d.cmd   = CMD_REF;
                    gap_load  = 1'b1;
                    gap_val   = CNT_W'(T_RFC - 1);
                end
                ST_TRFC1: begin
                    r_d.state = ST_TRFC2;
                    r_d.cmd   = CMD_REF;
                    gap_load  = 1'b1;
                    gap_val   = CNT_W'(T_RFC - 1);
                end
                ST_TRFC2: begin
                    r_d.state = ST_TMRD;
                    r_d.cmd   = CMD_MRS;
                    r_d.addr  = mode_word;
                    gap_load  = 1'b1;
                    gap_val   = CNT_W'(T_MRD - 1);
                end
                ST_TMRD: begin
                    r_d.state = ST_READY;
                    r_d.done  = 1'b1;
                end
                default: begin
                    r_d.state = ST_READY;
                    r_d.done  = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state <= ST_WAIT;
            r_q.cmd   <= CMD_NOP;
            r_q.ba    <= '0;
            r_q.addr  <= '0;
            r_q.done  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sd_cs_n   = 1'b0;
    assign sd_ras_n  = r_q.cmd[2];
    assign sd_cas_n  = r_q.cmd[1];
    assign sd_we_n   = r_q.cmd[0];
    assign sd_ba     = r_q.ba;
    assign sd_addr   = r_q.addr;
    assign init_done = r_q.done;

    // Observation counters for the assertions below
    logic [CNT_W:0] since_rst_q;
    logic [1:0]     ref_seen_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst_q <= '0;
            ref_seen_q  <= '0;
        end else begin
            if (since_rst_q <= (CNT_W+1)'(WAIT_CYCLES)) since_rst_q <= since_rst_q + 1'b1;
            if ({sd_ras_n, sd_cas_n, sd_we_n} == CMD_REF && ref_seen_q != 2'd3)
                ref_seen_q <= ref_seen_q + 1'b1;
        end
    end

    AST_WAIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ({sd_ras_n, sd_cas_n, sd_we_n} != CMD_NOP) |-> (since_rst_q > (CNT_W+1)'(WAIT_CYCLES))); // R2
    AST_PRE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        ({sd_ras_n, sd_cas_n, sd_we_n} == CMD_PRE) |-> sd_addr[ALL_BANK_BIT]);  // R3
    AST_TWO_REF: assert property (@(posedge clk) disable iff (!rst_n)
        ({sd_ras_n, sd_cas_n, sd_we_n} == CMD_MRS) |-> (ref_seen_q == 2'd2));   // R4
    AST_MRS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        ({sd_ras_n, sd_cas_n, sd_we_n} == CMD_MRS) |-> (sd_ba == '0 && sd_addr[12:10] == 3'b000 && sd_addr[8:7] == 2'b00)); // R6
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);                                               // R8
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111));      // R8
    AST_DONE_AFTER_MRS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> (ref_seen_q == 2'd2));                             // R7
endmodule

// File: tb/tb_sdram_init_seq.sv
module tb_sdram_init_seq;
    localparam int W     = 20;
    localparam int TRP   = 3;
    localparam int TRFC  = 5;
    localparam int TMRD  = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_burst_len = 3'd0;
    logic        cfg_burst_seq = 1'b0;
    logic [2:0]  cfg_cas_lat = 3'd0;
    logic        cfg_wr_single = 1'b0;
    logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0]  sd_ba;
    logic [12:0] sd_addr;
    logic        init_done;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    sdram_init_seq #(.WAIT_CYCLES(W), .T_RP(TRP), .T_RFC(TRFC), .T_MRD(TMRD)) dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_burst_len(cfg_burst_len), .cfg_burst_seq(cfg_burst_seq),
        .cfg_cas_lat(cfg_cas_lat), .cfg_wr_single(cfg_wr_single),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_ba(sd_ba), .sd_addr(sd_addr), .init_done(init_done)
    );

    function automatic logic [3:0] pins();
        return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 pins", 32'(pins()), 32'h7);
        check("R1 addr", 32'({sd_ba, sd_addr}), 32'h0);
        check("R1 done", 32'(init_done), 32'h0);
    endtask

    // Runs one full bring-up and checks command order, spacing and mode word
    task automatic run_init(input logic [2:0] bl, input logic bt, input logic [2:0] cl, input logic wb);
        int t_pre = -1, t_r1 = -1, t_r2 = -1, t_mrs = -1, t_done = -1, extra = 0;
        logic [12:0] mrs_addr = '0;
        logic [1:0]  mrs_ba = '1;
        logic        pre_a10 = 1'b0;
        cfg_burst_len = bl; cfg_burst_seq = bt; cfg_cas_lat = cl; cfg_wr_single = wb;
        apply_reset();
        rst_n = 1'b1;
        for (int i = 1; i < W + 60; i++) begin
            @(posedge clk); @(negedge clk);
            case (pins())
                4'b0111: ;
                4'b0010: if (t_pre < 0) begin t_pre = i; pre_a10 = sd_addr[10]; end else extra++;
                4'b0001: if (t_r1 < 0) t_r1 = i; else if (t_r2 < 0) t_r2 = i; else extra++;
                4'b0000: if (t_mrs < 0) begin t_mrs = i; mrs_addr = sd_addr; mrs_ba = sd_ba; end else extra++;
                default: extra++;
            endcase
            if (init_done && t_done < 0) t_done = i;
        end
        check("R2 precharge cycle", 32'(t_pre), 32'(W + 1));
        check("R3 all-bank bit", 32'(pre_a10), 32'h1);
        check("R4 first refresh", 32'(t_r1), 32'(W + 1 + TRP));
        check("R4 second refresh", 32'(t_r2), 32'(W + 1 + TRP + TRFC));
        check("R5 mode load", 32'(t_mrs), 32'(W + 1 + TRP + 2 * TRFC));
        check("R6 mode word", 32'(mrs_addr), 32'({3'b000, wb, 2'b00, cl, bt, bl}));
        check("R6 bank", 32'(mrs_ba), 32'h0);
        check("R7 done cycle", 32'(t_done), 32'(W + 1 + TRP + 2 * TRFC + TMRD));
        check("R7 stray commands", 32'(extra), 32'h0);
    endtask

    task automatic test_after_done();
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            cfg_burst_len = 3'(i); cfg_cas_lat = 3'(7 - i); cfg_wr_single = i[0];
            @(posedge clk); @(negedge clk);
            check("R8 bus idle", 32'({pins(), sd_addr}), 32'({4'b0111, 13'h0}));
            check("R8 done held", 32'(init_done), 32'h1);
        end
    endtask

    task automatic test_mid_reset();
        apply_reset();
        rst_n = 1'b1;
        repeat (W + 1 + TRP + 2) @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R9 pins after reset", 32'(pins()), 32'h7);
        check("R9 done after reset", 32'(init_done), 32'h0);
        run_init(3'b011, 1'b0, 3'b011, 1'b0);
    endtask

    initial begin
        run_init(3'b010, 1'b0, 3'b010, 1'b0);
        test_after_done();
        run_init(3'b111, 1'b1, 3'b011, 1'b1);
        test_mid_reset();
        run_init(3'b101, 1'b1, 3'b110, 1'b0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule